// File: doc/BRIEF.md
# Burst I2C Master with Single-Word Command

This block is an I2C bus master for a register-mapped host. Software loads a 7-bit target address, the SCL timing and timeout settings, and (for writes) a 32-bit data word. It then writes one control word. That word chooses whether a START and address phase come first, whether a STOP closes the cycle, the direction, a burst of one to four bytes, and whether the final read byte is answered with NACK. Setting the trigger bit in the same write runs the whole sequence on the bus. No further software action is needed until the trigger bit reads back as zero.

The SCL and SDA pins are open-drain. The block drives a low-enable for each pin and samples the pad levels. Read bytes are shifted into the data register so that the byte received last sits in bits 7:0. Written bytes are taken from the data register in the same order. A two-bit status field gives the outcome: success, missing acknowledge, timeout, or bus busy/unavailable. When the START bit is clear, a cycle continues the transfer already open on the bus. A long read can therefore be split into several chained commands.

Top module: `i2c_burst_master`

## Requirements
- R1: After reset, the control register (offset 0x00) and data register (offset 0x0C) read 0, and both `scl_oe` and `sda_oe` are low.
- R2: A control write with bit 31 set launches a cycle. While it runs, bit 31 reads 1 and status bits 30:29 read 3. On completion, bit 31 reads 0 and the status is 0 (success), 1 (no acknowledge) or 2 (timeout).
- R3: A read burst of N bytes (N in bits 8:6, values 1..4) clears the data register and shifts each received byte in from the bottom. The first byte lands in lane N-1 and the last byte in bits 7:0.
- R4: A write burst of N bytes sends data register lane N-1 first and lane 0 last.
- R5: With bit 0 set, the cycle begins with a START condition followed by the address byte {address[6:0], R/W}. R/W is 1 when bits 3:2 equal 1 (read) and 0 when they equal 2 (write). SDA changes only while SCL is low, except at START and STOP.
- R6: A missing acknowledge on the address byte or on any written byte stops the burst, with no further bytes sent, and sets status 1. When bit 1 is set, a STOP follows and both lines are released.
- R7: The master drives ACK after each read byte except the last one. The last byte gets NACK when bit 28 is set and ACK otherwise. With bit 0 clear, no START or address is sent and the burst continues the open transfer. With bit 1 clear, SCL stays held low after the cycle.
- R8: When timing bit 24 is set and SCL is held low by another device, the cycle aborts with status 2 and releases both lines. The abort comes once the low time exceeds the timing field in bits 23:16, counted in SCL periods. The SCL period in clocks is set by timing bits 11:0.
- R9: Unless pad bits 0, 14 and 15 (offset 0x20) are all set, a trigger write performs no bus activity and completes at once with bit 31 reading 0 and status 3.
- R10: All register writes made while bit 31 reads 1 are ignored. This holds even in the cycle where the transfer finishes; the running command and its results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 6 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| scl_in | input | 1 | Sampled SCL pad level |
| sda_in | input | 1 | Sampled SDA pad level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
Two functions can meet in one clock edge: the engine finishing a transfer, and a host write to the control register. The bench provokes this by writing a different control word on every cycle while the trigger bit still reads 1, and it keeps the write strobe asserted through the very edge at which the engine clears the trigger. The write at that edge must be dropped. This is judged at the ports: after completion, the data register holds the original read byte, the command field still shows a read, and the bus model has received no write bytes.

// File: rtl/i2c_burst_master.sv
module i2c_burst_master #(
  parameter int PERIOD_W = 12,
  parameter int STALL_W  = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  reg_addr,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        scl_oe,
  output logic        sda_oe
);
  localparam logic [5:0] OFF_CTRL = 6'h00;
  localparam logic [5:0] OFF_TGT  = 6'h04;
  localparam logic [5:0] OFF_TIM  = 6'h08;
  localparam logic [5:0] OFF_DATA = 6'h0C;
  localparam logic [5:0] OFF_PAD  = 6'h20;
  localparam int QW = PERIOD_W - 2;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BYTE, ST_STOP} state_t;

  state_t state;
  logic busy, gen_start, gen_stop, gen_nack, tmo_en, is_addr, ackv;
  logic pad_mode, pad_scl, pad_sda;
  logic [1:0] status, res, cmd, q;
  logic [2:0] burst, left;
  logic [3:0] bitn;
  logic [6:0] tgt;
  logic [7:0] tmo, sh;
  logic [31:0] data;
  logic [PERIOD_W-1:0] period;
  logic [QW-1:0] tcnt, qlim;
  logic [STALL_W-1:0] stall;

  function automatic logic [2:0] eff_len(input logic [2:0] b);
    if (b == 3'd0) return 3'd1;
    if (b[2]) return 3'd4;
    return b;
  endfunction

  function automatic logic [7:0] lane(input logic [31:0] d, input logic [2:0] n);
    case (n)
      3'd4: return d[31:24];
      3'd3: return d[23:16];
      3'd2: return d[15:8];
      default: return d[7:0];
    endcase
  endfunction

  wire pad_ok = pad_mode & pad_scl & pad_sda;
  wire rd     = (cmd == 2'd1);
  wire drive  = is_addr | ~rd;
  wire last   = (left == 3'd1);
  wire hold   = (state != ST_IDLE) && (q == 2'd2) && !scl_in;
  wire tick   = busy && (tcnt == qlim - 1'b1);
  wire host_w = reg_we && !busy;
  wire [2:0] w_len = eff_len(reg_wdata[8:6]);

  assign qlim = (period[PERIOD_W-1:2] == '0) ? QW'(1) : period[PERIOD_W-1:2];

  always_comb begin
    case (reg_addr)
      OFF_CTRL: reg_rdata = {busy, status, gen_nack, 19'b0, burst, 2'b0, cmd, gen_stop, gen_start};
      OFF_TGT:  reg_rdata = {25'b0, tgt};
      OFF_TIM:  reg_rdata = {7'b0, tmo_en, tmo, {(16-PERIOD_W){1'b0}}, period};
      OFF_DATA: reg_rdata = data;
      OFF_PAD:  reg_rdata = {16'b0, pad_sda, pad_scl, 13'b0, pad_mode};
      default:  reg_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; busy <= 1'b0; status <= 2'd0; res <= 2'd0;
      gen_start <= 1'b0; gen_stop <= 1'b0; gen_nack <= 1'b0; cmd <= 2'd0; burst <= 3'd0;
      tgt <= 7'd0; period <= '0; tmo <= 8'd0; tmo_en <= 1'b0; data <= 32'd0;
      pad_mode <= 1'b0; pad_scl <= 1'b0; pad_sda <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0; q <= 2'd0; tcnt <= '0; stall <= '0;
      bitn <= 4'd0; sh <= 8'd0; left <= 3'd0; is_addr <= 1'b0; ackv <= 1'b0;
    end else begin
      if (busy) tcnt <= tick ? '0 : tcnt + 1'b1;
      if (host_w) begin
        case (reg_addr)
          OFF_CTRL: begin
            gen_start <= reg_wdata[0]; gen_stop <= reg_wdata[1]; cmd <= reg_wdata[3:2];
            burst <= reg_wdata[8:6]; gen_nack <= reg_wdata[28];
            if (reg_wdata[31]) begin
              status <= 2'd3;
              if (pad_ok) begin
                busy <= 1'b1; res <= 2'd0; tcnt <= '0; q <= 2'd0; stall <= '0;
                bitn <= 4'd0; left <= w_len;
                if (reg_wdata[3:2] == 2'd1) data <= 32'd0;
                if (reg_wdata[0]) state <= ST_START;
                else begin
                  state <= ST_BYTE; is_addr <= 1'b0; sh <= lane(data, w_len);
                end
              end
            end
          end
          OFF_TGT:  tgt <= reg_wdata[6:0];
          OFF_TIM:  begin period <= reg_wdata[PERIOD_W-1:0]; tmo <= reg_wdata[23:16]; tmo_en <= reg_wdata[24]; end
          OFF_DATA: data <= reg_wdata;
          OFF_PAD:  begin pad_mode <= reg_wdata[0]; pad_scl <= reg_wdata[14]; pad_sda <= reg_wdata[15]; end
          default: ;
        endcase
      end else if (tick) begin
        if (hold) begin
          if (tmo_en && stall >= {tmo, 2'b00}) begin
            busy <= 1'b0; status <= 2'd2; state <= ST_IDLE; scl_oe <= 1'b0; sda_oe <= 1'b0;
          end else stall <= stall + 1'b1;
        end else begin
          stall <= '0;
          q <= q + 1'b1;
          case (state)
            ST_START: case (q)
              2'd0: sda_oe <= 1'b0;
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b1;
              default: begin
                scl_oe <= 1'b1; state <= ST_BYTE; is_addr <= 1'b1;
                bitn <= 4'd0; sh <= {tgt, rd};
              end
            endcase
            ST_STOP: case (q)
              2'd0: sda_oe <= 1'b1;
              2'd1: scl_oe <= 1'b0;
              2'd2: ;
              default: begin sda_oe <= 1'b0; busy <= 1'b0; status <= res; state <= ST_IDLE; end
            endcase
            ST_BYTE: case (q)
              2'd0: sda_oe <= (bitn < 4'd8) ? (drive & ~sh[7]) : (~drive & ~(last & gen_nack));
              2'd1: scl_oe <= 1'b0;
              2'd2: if (bitn < 4'd8) sh <= {sh[6:0], sda_in}; else ackv <= sda_in;
              default: begin
                scl_oe <= 1'b1;
                if (bitn < 4'd8) bitn <= bitn + 1'b1;
                else begin
                  bitn <= 4'd0;
                  if (rd && !is_addr) begin
                    data <= {data[23:0], sh};
                    left <= left - 1'b1;
                    if (last) begin
                      if (gen_stop) state <= ST_STOP;
                      else begin busy <= 1'b0; status <= 2'd0; state <= ST_IDLE; sda_oe <= 1'b0; end
                    end
                  end else if (ackv) begin
                    if (gen_stop) begin res <= 2'd1; state <= ST_STOP; end
                    else begin busy <= 1'b0; status <= 2'd1; state <= ST_IDLE; sda_oe <= 1'b0; end
                  end else if (is_addr) begin
                    is_addr <= 1'b0;
                    if (!rd) sh <= lane(data, left);
                  end else begin
                    left <= left - 1'b1;
                    if (last) begin
                      if (gen_stop) state <= ST_STOP;
                      else begin busy <= 1'b0; status <= 2'd0; state <= ST_IDLE; sda_oe <= 1'b0; end
                    end else sh <= lane(data, left - 1'b1);
                  end
                end
              end
            endcase
            default: ;
          endcase
        end
      end
    end
  end

  assert_busy_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> status == 2'd3);

  assert_done_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> status != 2'd3);

  assert_sda_framing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BYTE && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

  assert_busy_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == OFF_CTRL) |=> ($stable(cmd) && $stable(burst) && $stable(gen_stop)));
endmodule

// File: tb/i2c_burst_master_tb_top.sv
module i2c_burst_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] SLV = 7'h50;
  localparam logic [67:0] VEC [8] = '{
    {1'b1, 3'd1, 32'h0, 32'h000000A0},
    {1'b1, 3'd2, 32'h0, 32'h0000A0A1},
    {1'b1, 3'd3, 32'h0, 32'h00A0A1A2},
    {1'b1, 3'd4, 32'h0, 32'hA0A1A2A3},
    {1'b0, 3'd1, 32'h11223344, 32'h00000044},
    {1'b0, 3'd2, 32'h11223344, 32'h00003344},
    {1'b0, 3'd3, 32'h11223344, 32'h00223344},
    {1'b0, 3'd4, 32'h11223344, 32'h11223344}
  };

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [5:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic scl_oe, sda_oe, slv_hold = 0, slv_sda = 0;
  wire scl = !(scl_oe | slv_hold);
  wire sda = !(sda_oe | slv_sda);
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_burst_master dut_i (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_in(scl), .sda_in(sda),
    .scl_oe(scl_oe), .sda_oe(sda_oe));

  // bus target model
  logic ps = 1, pd = 1, got_rw = 0;
  logic [3:0] bn = 0;
  logic [7:0] rx = 0, tx = 0, ridx = 0, macks = 0;
  logic [1:0] md = 2'd3;
  logic [31:0] wlog = 0;
  int wcnt = 0, nak_at = 0;
  wire [7:0] nb = 8'hA0 + ridx;

  always @(posedge clk) begin
    ps <= scl; pd <= sda;
    if (ps && scl && pd && !sda) begin
      md <= 2'd0; bn <= 0; slv_sda <= 0; wlog <= 0; wcnt <= 0; ridx <= 0; macks <= 0;
    end else if (ps && scl && !pd && sda) md <= 2'd3;
    else if (!ps && scl) begin
      if (bn < 8) rx <= {rx[6:0], sda};
      else if (md == 2'd2) begin macks <= {macks[6:0], sda}; if (sda) md <= 2'd3; end
      bn <= bn + 1'b1;
    end else if (ps && !scl && md != 2'd3) begin
      if (bn == 8) begin
        if (md == 2'd0) begin
          if (rx[7:1] == SLV) begin slv_sda <= 1; md <= rx[0] ? 2'd2 : 2'd1; got_rw <= rx[0]; end
          else begin md <= 2'd3; slv_sda <= 0; end
        end else if (md == 2'd1) begin
          wlog <= {wlog[23:0], rx}; wcnt <= wcnt + 1; slv_sda <= (wcnt + 1 != nak_at);
        end else slv_sda <= 0;
      end else if (bn == 9) begin
        bn <= 0;
        if (md == 2'd2) begin tx <= nb; ridx <= ridx + 1'b1; slv_sda <= ~nb[7]; end
        else slv_sda <= 0;
      end else if (md == 2'd2) slv_sda <= ~tx[3'd7 - bn[2:0]];
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_done(output logic [31:0] c);
    int n = 0;
    do begin rd(6'h00, c); n++; end while (c[31] && n < 20000);
    if (c[31]) chk("R2 completion", c, 32'h0);
  endtask

  function automatic logic [31:0] mk(input bit st, input bit sp, input bit r,
                                     input logic [2:0] n, input bit nk);
    return {1'b1, 2'b00, nk, 19'b0, n, 2'b00, r ? 2'd1 : 2'd2, sp, st};
  endfunction

  initial begin
    logic [31:0] c, d;
    int act;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(6'h00, c); chk("R1 ctrl", c, 32'h0);
    rd(6'h0C, d); chk("R1 data", d, 32'h0);
    chk("R1 scl_oe", {31'b0, scl_oe}, 32'h0);
    chk("R1 sda_oe", {31'b0, sda_oe}, 32'h0);

    wr(6'h20, 32'h0000C001);
    wr(6'h08, 32'h01030008);
    wr(6'h04, {25'b0, SLV});

    // R2 running state visible
    wr(6'h00, mk(1, 1, 1, 3'd1, 1));
    rd(6'h00, c); chk("R2 trigger/status while busy", {30'b0, c[31], c[30] & c[29]}, 32'h3);
    wait_done(c);

    // table walk: R3 / R4 / R5 / R2
    for (int i = 0; i < 8; i++) begin
      logic [67:0] v = VEC[i];
      if (!v[67]) wr(6'h0C, v[63:32]);
      wr(6'h00, mk(1, 1, v[67], v[66:64], v[67]));
      wait_done(c);
      chk("R2 status ok", {30'b0, c[30:29]}, 32'h0);
      if (v[67]) begin rd(6'h0C, d); chk("R3 read packing", d, v[31:0]); end
      else chk("R4 write order", wlog, v[31:0]);
      chk("R5 rw bit", {31'b0, got_rw}, {31'b0, v[67]});
    end

    // R7 chained read: ACK first part, no STOP; then continue without START, NACK + STOP
    wr(6'h00, mk(1, 0, 1, 3'd2, 0));
    wait_done(c);
    rd(6'h0C, d); chk("R7 chain part1 data", d, 32'h0000A0A1);
    chk("R7 scl held low", {31'b0, scl_oe}, 32'h1);
    chk("R7 acks part1", {30'b0, macks[1:0]}, 32'h0);
    wr(6'h00, mk(0, 1, 1, 3'd2, 1));
    wait_done(c);
    rd(6'h0C, d); chk("R7 chain part2 data", d, 32'h0000A2A3);
    chk("R7 ack then nack", {28'b0, macks[3:0]}, 32'h1);
    chk("R7 released", {30'b0, scl_oe, sda_oe}, 32'h0);

    // R6 address not acknowledged
    wr(6'h04, 32'h31);
    wr(6'h0C, 32'h11223344);
    wr(6'h00, mk(1, 1, 0, 3'd2, 0));
    wait_done(c);
    chk("R6 addr nack status", {30'b0, c[30:29]}, 32'h1);
    chk("R6 addr nack no data", wlog, 32'h0);
    chk("R6 addr nack released", {30'b0, scl_oe, sda_oe}, 32'h0);
    wr(6'h04, {25'b0, SLV});

    // R6 data byte not acknowledged
    nak_at = 2;
    wr(6'h00, mk(1, 1, 0, 3'd4, 0));
    wait_done(c);
    nak_at = 0;
    chk("R6 data nack status", {30'b0, c[30:29]}, 32'h1);
    chk("R6 data nack stops burst", wlog, 32'h00001122);
    chk("R6 data nack released", {30'b0, scl_oe, sda_oe}, 32'h0);

    // R8 timeout with SCL held low
    slv_hold = 1;
    wr(6'h00, mk(1, 1, 1, 3'd1, 1));
    repeat (10) @(negedge clk);
    rd(6'h00, c); chk("R8 still waiting", {31'b0, c[31]}, 32'h1);
    wait_done(c);
    chk("R8 timeout status", {30'b0, c[30:29]}, 32'h2);
    chk("R8 lines released", {30'b0, scl_oe, sda_oe}, 32'h0);
    slv_hold = 0;
    repeat (4) @(negedge clk);

    // R9 pads disabled
    wr(6'h20, 32'h00004001);
    wr(6'h00, mk(1, 1, 1, 3'd1, 1));
    rd(6'h00, c);
    chk("R9 immediate done", {29'b0, c[31:29]}, 32'h3);
    act = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (scl_oe | sda_oe) act++; end
    chk("R9 no bus activity", act, 0);
    wr(6'h20, 32'h0000C001);

    // R10 control writes during the run, up to the completing edge
    wr(6'h00, mk(1, 1, 1, 3'd1, 1));
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk); reg_addr = 6'h00; #1;
      if (reg_rdata[31]) begin reg_wdata = mk(1, 1, 0, 3'd4, 0); reg_we = 1; end
      else begin reg_we = 0; break; end
    end
    reg_we = 0;
    rd(6'h00, c);
    chk("R10 command kept", {30'b0, c[3:2]}, 32'h1);
    chk("R10 status ok", {29'b0, c[31:29]}, 32'h0);
    rd(6'h0C, d); chk("R10 read result kept", d, 32'h000000A0);
    chk("R10 no write on bus", wlog, 32'h0);

    summary();
    $finish;
  end
endmodule